// File: doc/BRIEF.md
# Banked Hardware-Monitor Register Core

This block is the register core of a motherboard hardware monitor. Host software reaches it in two ways. The first is an eight-offset I/O window that works through an index port and a data port. The second is a command interface in the SMBus style, which answers only at the block's own programmable 7-bit address. Behind both sits a 256-entry byte array. Part of its numbering is aliased: 0x60–0x7F fold onto 0x20–0x3F and, when the mirror option is built in, 0x80–0x92 fold onto 0x00–0x12.

Some registers configure the block itself:
- A bank register selects a bank. While bank 1 or 2 is active, any access whose register number has upper nibble 5 goes to one of two companion temperature-sensor ports instead of the array.
- One register holds the block's own bus address.
- Another register derives the bus addresses of the two companion sensors and can disable either one.
- One register returns a byte of a fixed 16-bit vendor identifier.
- Setting an initialization bit reloads the array but keeps the current bus address.
- In the mirror variant, a trigger register raises a one-cycle system-reset request.

The I/O window and the command interface can present an access in the same cycle. The I/O window then wins, and the command access is not granted.

Top module: `hwmon_regcore`

## Requirements
- R1: An I/O write at offset 5 loads the index register with the low 7 bits of the data. An I/O read at offset 5 returns {0, index}.
- R2: Offset 6 reads and writes the register selected by the index. A read at any other offset returns 0xFF, and a write at any other offset changes nothing.
- R3: Register numbers 0x60–0x7F read and write entry (number & 0x3F).
- R4: With MIRROR_EN=1, register numbers 0x80–0x92 read and write entry (number − 0x80). 0x93 and above are separate entries.
- R5: After reset the entries hold these values:
  - 0xC0–0xDF hold 0xFF.
  - 0x47 holds 0x50.
  - 0x48 holds 0x2D.
  - 0x4A holds 0x01.
  - All other entries hold 0.
- R6: ownAddr equals bits [6:0] of register 0x48. A command access is acknowledged only when smbAddr equals ownAddr and ownAddr is non-zero. A write to 0x48 takes effect from the next cycle.
- R7: compAddrA is 0x48 + reg4A[2:0], and compAddrB is 0x48 + reg4A[6:4]. Each reads 0 when reg4A bit 3 (for A) or bit 7 (for B) is set.
- R8: When reg4E[2:0] is 1 or 2 and the upper nibble of the register number is 5, the access goes to companion port 1 or 2, as follows:
  - Exactly one compReq bit is set.
  - compReg carries the low 3 bits of the register number.
  - Read data comes from compRdata0 or compRdata1.
  - The array is left untouched.
- R9: A read of register 0x4F returns VENDOR_ID[15:8] when reg4E bit 7 is set, and VENDOR_ID[7:0] otherwise.
- R10: A write to register 0x40 with bit 7 set restores every entry to its R5 value, except that 0x48 keeps its current value.
- R11: With MIRROR_EN=1, writing 0x01 to register 0x87 raises sysResetReq for exactly the next cycle. Any other value raises nothing.
- R12: smbKind encodings are: 0 send-byte (loads index), 1 receive-byte (reads at index), 2 write-byte, 3 read-byte, 4 write-word, 5 read-word. smbCmd selects the register for kinds 2–5.
  - Byte reads return {0x00, byte}.
  - A word read returns the byte in both halves.
  - Both writes store smbWdata, which is the data low byte.
  - Every access uses the active bank.
- R13: While isaValid is high, smbGrant and smbAck are low and the command access has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| isaValid | input | 1 | I/O window access this cycle |
| isaWrite | input | 1 | 1 = write, 0 = read |
| isaOffset | input | 3 | Offset within the window |
| isaWdata | input | 8 | I/O write data |
| isaRdata | output | 8 | I/O read data |
| smbValid | input | 1 | Command access this cycle |
| smbAddr | input | 7 | Target bus address |
| smbKind | input | 3 | Command kind (R12) |
| smbCmd | input | 8 | Command / register number |
| smbWdata | input | 8 | Write data (low byte) |
| smbRdata | output | 16 | Command read data |
| smbGrant | output | 1 | Command access granted by the arbiter |
| smbAck | output | 1 | Command access granted and addressed to this block |
| ownAddr | output | 7 | Current own bus address |
| compAddrA | output | 7 | Companion 1 address (0 = disabled) |
| compAddrB | output | 7 | Companion 2 address (0 = disabled) |
| compReq | output | 2 | Routed access to companion 1 (bit 0) or 2 (bit 1) |
| compWrite | output | 1 | Routed access is a write |
| compReg | output | 3 | Companion register number |
| compWdata | output | 8 | Companion write data |
| compRdata0 | input | 8 | Read data from companion 1 |
| compRdata1 | input | 8 | Read data from companion 2 |
| sysResetReq | output | 1 | One-cycle system reset request |

## Verification
Routing to the companions and the reset trigger both depend on earlier writes. A bank must already be selected in 0x4E before a 0x5x access reroutes, and the trigger needs the mirror window at 0x87. The bench therefore sets up these sequences directly, and its random phase also writes to the bank register freely. The initialization bit clears the whole array, including the bank, while the address is kept. To reach that state, the bench issues it in the middle of a run with a moved address and aliased data, then checks that the address remains reachable.

// File: rtl/hwmon_pkg.sv
`timescale 1ns/1ps
package hwmon_pkg;
  typedef enum logic [2:0] {
    SMB_SEND = 3'd0,
    SMB_RECV = 3'd1,
    SMB_WRB  = 3'd2,
    SMB_RDB  = 3'd3,
    SMB_WRW  = 3'd4,
    SMB_RDW  = 3'd5
  } smbKind_e;

  // Strobes from control to datapath: one access per cycle at most
  typedef struct packed {
    logic       access;
    logic       wrEn;
    logic [7:0] regNum;
    logic [7:0] wdata;
    logic       idxWr;
    logic [6:0] idxVal;
  } strobe_t;

  localparam logic [2:0] OFS_INDEX   = 3'd5;
  localparam logic [2:0] OFS_DATA    = 3'd6;
  localparam logic [7:0] REG_CFG     = 8'h40;
  localparam logic [7:0] REG_ADDR    = 8'h48;
  localparam logic [7:0] REG_COMPCFG = 8'h4A;
  localparam logic [7:0] REG_BANK    = 8'h4E;
  localparam logic [7:0] REG_VID     = 8'h4F;
  localparam logic [7:0] REG_RSTTRIG = 8'h87;
endpackage

// File: rtl/hwmon_ctrl.sv
`timescale 1ns/1ps
module hwmon_ctrl
  import hwmon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        isaValid,
  input  logic        isaWrite,
  input  logic [2:0]  isaOffset,
  input  logic [7:0]  isaWdata,
  input  logic        smbValid,
  input  logic [6:0]  smbAddr,
  input  logic [2:0]  smbKind,
  input  logic [7:0]  smbCmd,
  input  logic [7:0]  smbWdata,
  input  logic [6:0]  idx,
  input  logic [6:0]  ownAddr,
  input  logic [7:0]  rdByte,
  output strobe_t     st,
  output logic [7:0]  isaRdata,
  output logic [15:0] smbRdata,
  output logic        smbGrant,
  output logic        smbAck
);
  smbKind_e kind;
  assign kind = smbKind_e'(smbKind);

  always_comb begin
    smbGrant = smbValid && !isaValid;
    smbAck   = smbGrant && (ownAddr != 7'd0) && (smbAddr == ownAddr);
    st        = '0;
    st.regNum = {1'b0, idx};
    if (isaValid) begin
      if (isaOffset == OFS_INDEX && isaWrite) begin
        st.idxWr  = 1'b1;
        st.idxVal = isaWdata[6:0];
      end else if (isaOffset == OFS_DATA) begin
        st.access = 1'b1;
        st.wrEn   = isaWrite;
        st.wdata  = isaWdata;
      end
    end else if (smbAck) begin
      unique case (kind)
        SMB_SEND: begin
          st.idxWr  = 1'b1;
          st.idxVal = smbWdata[6:0];
        end
        SMB_RECV: st.access = 1'b1;
        SMB_WRB, SMB_WRW: begin
          st.access = 1'b1;
          st.wrEn   = 1'b1;
          st.regNum = smbCmd;
          st.wdata  = smbWdata;
        end
        SMB_RDB, SMB_RDW: begin
          st.access = 1'b1;
          st.regNum = smbCmd;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (isaOffset == OFS_INDEX)     isaRdata = {1'b0, idx};
    else if (isaOffset == OFS_DATA) isaRdata = rdByte;
    else                            isaRdata = 8'hFF;
    smbRdata = (kind == SMB_RDW) ? {rdByte, rdByte} : {8'h00, rdByte};
  end

  // R13: the I/O window always wins the cycle
  assert_isa_first_R13: assert property (@(posedge clk) disable iff (!rstN)
    isaValid |-> (!smbGrant && !smbAck));
endmodule

// File: rtl/hwmon_regfile.sv
`timescale 1ns/1ps
module hwmon_regfile
  import hwmon_pkg::*;
#(
  parameter bit          MIRROR_EN   = 1'b1,
  parameter bit          SMB_PRESENT = 1'b1,
  parameter logic [15:0] VENDOR_ID   = 16'h5CA3,
  parameter int          DEPTH       = 256
)(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    st,
  output logic [7:0] rdByte,
  output logic [6:0] idx,
  output logic [6:0] ownAddr,
  output logic [6:0] compAddrA,
  output logic [6:0] compAddrB,
  output logic [1:0] compReq,
  output logic       compWrite,
  output logic [2:0] compReg,
  output logic [7:0] compWdata,
  input  logic [7:0] compRdata0,
  input  logic [7:0] compRdata1,
  output logic       sysResetReq
);
  localparam int NUM_COMP = 2;
  localparam logic [6:0] COMP_BASE = 7'h48;

  logic [7:0] mem [DEPTH];
  logic [6:0] idxQ;
  logic       rstReqQ;
  logic [2:0] bank;
  logic [7:0] eff;
  logic       routed, softInit, resetHit;
  logic [6:0] compAddr [NUM_COMP];

  function automatic logic [7:0] initVal(input logic [7:0] i);
    if (i >= 8'hC0 && i <= 8'hDF) return 8'hFF;
    if (i == 8'h47)               return 8'h50;
    if (i == REG_ADDR)            return SMB_PRESENT ? 8'h2D : 8'h00;
    if (i == REG_COMPCFG)         return SMB_PRESENT ? 8'h01 : 8'h88;
    return 8'h00;
  endfunction

  function automatic logic [7:0] effIdx(input logic [7:0] r);
    if (r[7:5] == 3'b011) return {2'b00, r[5:0]};
    if (MIRROR_EN && r >= 8'h80 && r <= 8'h92) return {1'b0, r[6:0]};
    return r;
  endfunction

  assign bank     = mem[REG_BANK][2:0];
  assign eff      = effIdx(st.regNum);
  assign routed   = (bank == 3'd1 || bank == 3'd2) && st.regNum[7:4] == 4'h5;
  assign softInit = st.wrEn && !routed && eff == REG_CFG && st.wdata[7];
  assign resetHit = MIRROR_EN && st.wrEn && st.regNum == REG_RSTTRIG && st.wdata == 8'h01;

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
    assign compReq[k]  = st.access && routed && bank == 3'(k + 1);
    assign compAddr[k] = (SMB_PRESENT && !mem[REG_COMPCFG][4*k+3])
                         ? COMP_BASE + 7'(mem[REG_COMPCFG][4*k +: 3]) : 7'd0;
  end
  assign compAddrA = compAddr[0];
  assign compAddrB = compAddr[1];
  assign compWrite = st.wrEn;
  assign compReg   = st.regNum[2:0];
  assign compWdata = st.wdata;
  assign ownAddr   = SMB_PRESENT ? mem[REG_ADDR][6:0] : 7'd0;
  assign idx         = idxQ;
  assign sysResetReq = rstReqQ;

  always_comb begin
    if (routed)                   rdByte = (bank == 3'd1) ? compRdata0 : compRdata1;
    else if (st.regNum == REG_VID) rdByte = mem[REG_BANK][7] ? VENDOR_ID[15:8] : VENDOR_ID[7:0];
    else                          rdByte = mem[eff];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= initVal(8'(i));
      idxQ    <= '0;
      rstReqQ <= 1'b0;
    end else begin
      rstReqQ <= resetHit;
      if (st.idxWr) idxQ <= st.idxVal;
      if (softInit) begin
        for (int i = 0; i < DEPTH; i++)
          if (8'(i) != REG_ADDR) mem[i] <= initVal(8'(i));
      end else if (st.wrEn && !routed) begin
        mem[eff] <= st.wdata;
      end
    end
  end

  assert_idx_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    st.idxWr |=> (idx == $past(st.idxVal)));
  assert_comp_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(compReq));
  assert_rst_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |=> !sysResetReq);
  assert_rst_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> $past(st.wrEn && st.regNum == REG_RSTTRIG && st.wdata == 8'h01));
endmodule

// File: rtl/hwmon_regcore.sv
`timescale 1ns/1ps
module hwmon_regcore
  import hwmon_pkg::*;
#(
  parameter bit          MIRROR_EN   = 1'b1,
  parameter bit          SMB_PRESENT = 1'b1,
  parameter logic [15:0] VENDOR_ID   = 16'h5CA3
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        isaValid,
  input  logic        isaWrite,
  input  logic [2:0]  isaOffset,
  input  logic [7:0]  isaWdata,
  output logic [7:0]  isaRdata,
  input  logic        smbValid,
  input  logic [6:0]  smbAddr,
  input  logic [2:0]  smbKind,
  input  logic [7:0]  smbCmd,
  input  logic [7:0]  smbWdata,
  output logic [15:0] smbRdata,
  output logic        smbGrant,
  output logic        smbAck,
  output logic [6:0]  ownAddr,
  output logic [6:0]  compAddrA,
  output logic [6:0]  compAddrB,
  output logic [1:0]  compReq,
  output logic        compWrite,
  output logic [2:0]  compReg,
  output logic [7:0]  compWdata,
  input  logic [7:0]  compRdata0,
  input  logic [7:0]  compRdata1,
  output logic        sysResetReq
);
  strobe_t    st;
  logic [7:0] rdByte;
  logic [6:0] idx;

  hwmon_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .isaValid(isaValid), .isaWrite(isaWrite), .isaOffset(isaOffset), .isaWdata(isaWdata),
    .smbValid(smbValid), .smbAddr(smbAddr), .smbKind(smbKind), .smbCmd(smbCmd),
    .smbWdata(smbWdata), .idx(idx), .ownAddr(ownAddr), .rdByte(rdByte),
    .st(st), .isaRdata(isaRdata), .smbRdata(smbRdata), .smbGrant(smbGrant), .smbAck(smbAck)
  );

  hwmon_regfile #(.MIRROR_EN(MIRROR_EN), .SMB_PRESENT(SMB_PRESENT), .VENDOR_ID(VENDOR_ID)) u_regs (
    .clk(clk), .rstN(rstN), .st(st), .rdByte(rdByte), .idx(idx), .ownAddr(ownAddr),
    .compAddrA(compAddrA), .compAddrB(compAddrB), .compReq(compReq), .compWrite(compWrite),
    .compReg(compReg), .compWdata(compWdata), .compRdata0(compRdata0), .compRdata1(compRdata1),
    .sysResetReq(sysResetReq)
  );
endmodule

// File: tb/sim_hwmon_regcore.sv
`timescale 1ns/1ps
module sim_hwmon_regcore;
  localparam int K_SEND = 0, K_RECV = 1, K_WRB = 2, K_RDB = 3, K_WRW = 4, K_RDW = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic isaValid = 0, isaWrite = 0;
  logic [2:0] isaOffset = 0;
  logic [7:0] isaWdata = 0, isaRdata;
  logic smbValid = 0;
  logic [6:0] smbAddr = 0;
  logic [2:0] smbKind = 0;
  logic [7:0] smbCmd = 0, smbWdata = 0;
  logic [15:0] smbRdata;
  logic smbGrant, smbAck, compWrite, sysResetReq;
  logic [6:0] ownAddr, compAddrA, compAddrB;
  logic [1:0] compReq;
  logic [2:0] compReg;
  logic [7:0] compWdata, compRdata0, compRdata1;

  always #5 clk = ~clk;

  assign compRdata0 = 8'hA0 | {5'd0, compReg};
  assign compRdata1 = 8'hB0 | {5'd0, compReg};

  hwmon_regcore u0 (.*);

  int vectors = 0, miscompares = 0;
  bit done = 0;
  bit [7:0] mm [256];
  bit [6:0] mIdx = 0;
  bit expRst = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] initOf(int i);
    if (i >= 'hC0 && i <= 'hDF) return 8'hFF;
    if (i == 'h47) return 8'h50;
    if (i == 'h48) return 8'h2D;
    if (i == 'h4A) return 8'h01;
    return 8'h00;
  endfunction

  function automatic bit [7:0] aliasOf(bit [7:0] r);
    if (r >= 8'h60 && r <= 8'h7F) return r & 8'h3F;
    if (r >= 8'h80 && r <= 8'h92) return r - 8'h80;
    return r;
  endfunction

  function automatic int bankOf();
    return int'(mm[8'h4E][2:0]);
  endfunction

  function automatic bit isRouted(bit [7:0] r);
    return (bankOf() == 1 || bankOf() == 2) && r[7:4] == 4'h5;
  endfunction

  function automatic bit [7:0] modelRead(bit [7:0] r);
    if (isRouted(r)) return ((bankOf() == 1) ? 8'hA0 : 8'hB0) | {5'd0, r[2:0]};
    if (r == 8'h4F) return mm[8'h4E][7] ? 8'h5C : 8'hA3;
    return mm[aliasOf(r)];
  endfunction

  task automatic modelWrite(bit [7:0] r, bit [7:0] v);
    bit [7:0] e, keep;
    if (isRouted(r)) return;
    e = aliasOf(r);
    if (e == 8'h40 && v[7]) begin
      keep = mm[8'h48];
      for (int i = 0; i < 256; i++) mm[i] = initOf(i);
      mm[8'h48] = keep;
    end else mm[e] = v;
    if (r == 8'h87 && v == 8'h01) expRst = 1;
  endtask

  task automatic checkComp(bit wr, bit [7:0] r, bit [7:0] d);
    bit [1:0] expReq;
    expReq = !isRouted(r) ? 2'b00 : (bankOf() == 1 ? 2'b01 : 2'b10);
    chk("R8 compReq", {14'd0, compReq}, {14'd0, expReq});
    if (expReq != 0) begin
      chk("R8 compReg", {13'd0, compReg}, {13'd0, r[2:0]});
      chk("R8 compWrite", {15'd0, compWrite}, {15'd0, wr});
      if (wr) chk("R8 compWdata", {8'd0, compWdata}, {8'd0, d});
    end
  endtask

  function automatic bit [6:0] cAddr(int k);
    bit [7:0] c = mm[8'h4A];
    if (c[4*k+3]) return 7'd0;
    return 7'h48 + 7'(c[4*k +: 3]);
  endfunction

  task automatic postCheck();
    chk("R11 sysResetReq", {15'd0, sysResetReq}, {15'd0, expRst});
    expRst = 0;
    chk("R6 ownAddr", {9'd0, ownAddr}, {9'd0, mm[8'h48][6:0]});
    chk("R7 compAddrA", {9'd0, compAddrA}, {9'd0, cAddr(0)});
    chk("R7 compAddrB", {9'd0, compAddrB}, {9'd0, cAddr(1)});
  endtask

  task automatic isaOp(bit wr, bit [2:0] off, bit [7:0] d, string tag);
    bit [7:0] exp;
    isaValid = 1; isaWrite = wr; isaOffset = off; isaWdata = d;
    #1;
    if (!wr) begin
      exp = (off == 5) ? {1'b0, mIdx} : (off == 6) ? modelRead({1'b0, mIdx}) : 8'hFF;
      chk(tag, {8'd0, isaRdata}, {8'd0, exp});
    end
    if (off == 6) checkComp(wr, {1'b0, mIdx}, d);
    if (wr && off == 5) mIdx = d[6:0];
    else if (wr && off == 6) modelWrite({1'b0, mIdx}, d);
    @(negedge clk);
    isaValid = 0;
    postCheck();
  endtask

  task automatic smbOp(int k, bit [6:0] a, bit [7:0] c, bit [7:0] d, string tag);
    bit ack;
    bit [7:0] v;
    smbValid = 1; smbKind = 3'(k); smbAddr = a; smbCmd = c; smbWdata = d;
    #1;
    ack = (a == mm[8'h48][6:0]) && (a != 0);
    chk("R6 smbAck", {15'd0, smbAck}, {15'd0, ack});
    if (ack) begin
      case (k)
        K_SEND: mIdx = d[6:0];
        K_RECV: begin
          v = modelRead({1'b0, mIdx});
          chk(tag, smbRdata, {8'd0, v});
          checkComp(0, {1'b0, mIdx}, 0);
        end
        K_RDB: begin
          chk(tag, smbRdata, {8'd0, modelRead(c)});
          checkComp(0, c, 0);
        end
        K_RDW: begin
          v = modelRead(c);
          chk(tag, smbRdata, {v, v});
          checkComp(0, c, 0);
        end
        K_WRB, K_WRW: begin
          checkComp(1, c, d);
          modelWrite(c, d);
        end
        default: ;
      endcase
    end
    @(negedge clk);
    smbValid = 0;
    postCheck();
  endtask

  task automatic isaReadReg(bit [6:0] r, string tag);
    isaOp(1, 5, {1'b0, r}, "R1 index write");
    isaOp(0, 6, 0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    bit [7:0] r, v;
    void'($urandom(32'd20250));
    for (int i = 0; i < 256; i++) mm[i] = initOf(i);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R5 reset state
    postCheck();
    isaReadReg(7'h47, "R5 reg47");
    isaReadReg(7'h48, "R5 reg48");
    isaReadReg(7'h4A, "R5 reg4A");
    isaReadReg(7'h10, "R5 reg10");
    smbOp(K_RDB, 7'h2D, 8'hC5, 0, "R5 regC5");
    smbOp(K_RDB, 7'h2D, 8'hDF, 0, "R5 regDF");
    smbOp(K_RDB, 7'h2D, 8'hE0, 0, "R5 regE0");
    // R1/R2 index readback and other offsets
    isaOp(1, 5, 8'hD3, "R1 index write");
    isaOp(0, 5, 0, "R1 index readback");
    isaOp(1, 3, 8'h11, "R2 ignored offset");
    isaOp(0, 5, 0, "R2 index unchanged");
    isaOp(0, 2, 0, "R2 offset2 FF");
    isaOp(0, 7, 0, "R2 offset7 FF");
    // R3 alias
    isaOp(1, 5, 8'h65, "R1 index write");
    isaOp(1, 6, 8'h3C, "R3 write 65");
    isaReadReg(7'h25, "R3 read 25");
    // R4 mirror
    smbOp(K_WRB, 7'h2D, 8'h83, 8'h77, "R4 write 83");
    isaReadReg(7'h03, "R4 read 03");
    smbOp(K_WRB, 7'h2D, 8'h93, 8'h44, "R4 write 93");
    smbOp(K_RDB, 7'h2D, 8'h13, 0, "R4 read 13");
    smbOp(K_RDB, 7'h2D, 8'h93, 0, "R4 read 93");
    // R12 command kinds
    smbOp(K_SEND, 7'h2D, 0, 8'h25, "R12 send");
    isaOp(0, 5, 0, "R12 index after send");
    smbOp(K_RECV, 7'h2D, 0, 0, "R12 receive");
    smbOp(K_WRW, 7'h2D, 8'h30, 8'h9E, "R12 word write");
    smbOp(K_RDW, 7'h2D, 8'h30, 0, "R12 word read");
    // R9 vendor id
    smbOp(K_RDB, 7'h2D, 8'h4F, 0, "R9 low byte");
    smbOp(K_WRB, 7'h2D, 8'h4E, 8'h80, "R9 set hb");
    smbOp(K_RDB, 7'h2D, 8'h4F, 0, "R9 high byte");
    // R8 bank routing
    smbOp(K_WRB, 7'h2D, 8'h4E, 8'h01, "R8 bank1");
    smbOp(K_RDB, 7'h2D, 8'h53, 0, "R8 read comp1");
    smbOp(K_WRB, 7'h2D, 8'h55, 8'h99, "R8 write comp1");
    smbOp(K_WRB, 7'h2D, 8'h4E, 8'h02, "R8 bank2");
    smbOp(K_RDW, 7'h2D, 8'h56, 0, "R8 read comp2");
    smbOp(K_WRB, 7'h2D, 8'h4E, 8'h03, "R8 bank3");
    smbOp(K_RDB, 7'h2D, 8'h55, 0, "R8 bank3 array");
    // R7 companion addresses
    smbOp(K_WRB, 7'h2D, 8'h4A, 8'h88, "R7 both off");
    smbOp(K_WRB, 7'h2D, 8'h4A, 8'h35, "R7 35");
    // R6 re-address
    smbOp(K_WRB, 7'h2D, 8'h48, 8'h2E, "R6 move");
    smbOp(K_RDB, 7'h2D, 8'h47, 0, "R6 old addr");
    smbOp(K_RDB, 7'h2E, 8'h47, 0, "R6 new addr");
    // R10 soft init keeps address
    isaOp(1, 5, 8'h40, "R1 index write");
    isaOp(1, 6, 8'h80, "R10 init");
    smbOp(K_RDB, 7'h2E, 8'h65, 0, "R10 alias cleared");
    smbOp(K_RDB, 7'h2E, 8'h4A, 0, "R10 4A restored");
    // R11 reset trigger
    smbOp(K_WRB, 7'h2E, 8'h87, 8'h02, "R11 no trigger");
    smbOp(K_WRB, 7'h2E, 8'h87, 8'h01, "R11 trigger");
    smbOp(K_RDB, 7'h2E, 8'h07, 0, "R11 mirror stored");
    // R13 priority
    smbValid = 1; smbKind = 3'(K_WRB); smbAddr = 7'h2E; smbCmd = 8'h10; smbWdata = 8'h55;
    isaValid = 1; isaWrite = 1; isaOffset = 5; isaWdata = 8'h10;
    #1;
    chk("R13 grant", {15'd0, smbGrant}, 16'd0);
    chk("R13 ack", {15'd0, smbAck}, 16'd0);
    mIdx = 7'h10;
    @(negedge clk);
    smbValid = 0; isaValid = 0;
    postCheck();
    isaOp(0, 6, 0, "R13 smb write dropped");
    // random phase
    for (int n = 0; n < 800; n++) begin
      r = 8'($urandom);
      v = 8'($urandom);
      if (aliasOf(r) == 8'h48 || aliasOf({1'b0, mIdx}) == 8'h48) v = 8'h2D + 8'($urandom % 3);
      if ($urandom % 2) begin
        case ($urandom % 6)
          0: isaOp(1, 5, v, "R1 rand index");
          1: isaOp(1, 6, v, "R2 rand write");
          2: isaOp(0, 6, 0, "R2 rand read");
          3: isaOp(0, 5, 0, "R1 rand index read");
          default: isaOp($urandom % 2, 3'($urandom), v, "R2 rand offset");
        endcase
      end else begin
        smbOp($urandom % 6, ($urandom % 4 == 0) ? 7'($urandom) : mm[8'h48][6:0],
              r, v, "R12 rand command");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule